// File: doc/BRIEF.md
# Remote Bus Access Sequencer

This block sits on the host side of a remote backplane link. It turns plain register reads and writes into single-word transfers on the remote bus. The host loads a 12-bit target address, then touches a data register. A write to the data register sends one remote write. A read of the data register fetches one remote word. The block also issues a remote initialisation command on request.

The remote side is a request/acknowledge handshake. The block raises a request and holds the address, direction and write word stable until the remote side answers with a one-cycle acknowledge, which carries read data on the same cycle. If no acknowledge arrives within a fixed 10 µs window, the transfer is abandoned. A one-cycle error pulse then reports whether the lost transfer was a read, a write or an initialisation. The window length in clock cycles comes from the clock frequency parameter.

A block mode serves auto-incrementing remote data ports. While it is on, the first transfer captures the address, and every later transfer reuses that captured address, whatever the address register holds. A 32-bit remote register is reached by two word transfers: the high half at the even address, then the low half at the next odd address.

Top module: `rba_seq`

## Requirements
- R1: The address register (select code 0) keeps 12 bits; reading it returns those bits with bits 15..12 always zero, and the written bits 15..12 are discarded.
- R2: A host write to the data register (select code 1) starts exactly one remote write. The request carries write-enable high, init low, the current address and the written word.
- R3: A host read strobe on the data register starts one remote read with write-enable low. Once the wait output falls, the data register returns the word that came with the acknowledge.
- R4: If a remote read gets no acknowledge, the request stays up for exactly TMO_CYC cycles (CLK_HZ × 10 µs), then drops. The read error output then pulses for one cycle, and the data register reads 0x0000.
- R5: If a remote write gets no acknowledge within the same window, the write error output pulses for one cycle, and the read and init error outputs stay low.
- R6: Writing a 1 to bit 0 of the control register (select code 2) issues one remote initialisation request, with init high and write-enable low. The bit reads back as 0. A missing acknowledge pulses the init error output.
- R7: While control bit 1 (block mode) is set, the first data transfer captures the address, and later transfers reuse it even after the address register changes. Clearing the bit returns to using the address register. The bit reads back as written.
- R8: While a transfer is in flight the wait output is high. A data access or init command issued in that time is dropped, not queued.
- R9: A request, once raised, keeps its address and write word stable and falls only after an acknowledge or a timeout. At most one error output is high in any cycle.
- R10: Two consecutive data writes to an even address and then the following odd address reach the remote bus as two transfers, in that order, each with its own address and word.
- R11: After reset the request, wait and error outputs are low, and the address register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe (launches a read on the data register) |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Contents of the selected register |
| host_wait | output | 1 | High while a remote transfer is in flight |
| rb_req | output | 1 | Remote request |
| rb_we | output | 1 | Remote write enable (valid with request) |
| rb_init | output | 1 | Remote initialisation command (valid with request) |
| rb_addr | output | 12 | Remote word address |
| rb_wdata | output | 16 | Remote write word |
| rb_ack | input | 1 | One-cycle remote acknowledge |
| rb_rdata | input | 16 | Remote read word, valid with acknowledge |
| err_rd | output | 1 | One-cycle pulse: read timed out |
| err_wr | output | 1 | One-cycle pulse: write timed out |
| err_init | output | 1 | One-cycle pulse: initialisation timed out |

## Verification
The assertions assume that the remote side acknowledges only while a request is up, and only for one cycle at a time. They also assume the host raises each strobe for a single cycle. The bench's responder model raises the acknowledge only after it has seen the request, for a programmable delay, and drops it at the next falling edge. Every host strobe comes from a task that holds it for exactly one cycle. In the timeout scenarios the responder is disabled, so the full window runs out.

// File: rtl/rba_pkg.sv
package rba_pkg;

    localparam int RB_AW = 12;
    localparam int RB_DW = 16;

    localparam int CTRL_INIT_BIT  = 0;
    localparam int CTRL_BLOCK_BIT = 1;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_INIT  = 2'd2
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } xfer_st_e;

    typedef struct packed {
        op_e              op;
        logic [RB_AW-1:0] addr;
        logic [RB_DW-1:0] wdata;
    } xfer_s;

    // Cycles in a no-response window of ns nanoseconds at hz, never below 2.
    function automatic int unsigned tmo_cycles(input longint unsigned hz,
                                               input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns) / 64'd1_000_000_000;
        if (c < 64'd2) c = 64'd2;
        return c[31:0];
    endfunction

endpackage

// File: rtl/rba_host_regs.sv
module rba_host_regs
    import rba_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [RB_DW-1:0] host_wdata,
    input  logic             busy,
    input  logic [RB_DW-1:0] rd_word,
    output logic [RB_DW-1:0] host_rdata,
    output logic             launch_vld,
    output xfer_s            launch_x
);

    logic [RB_AW-1:0] addr_q;
    logic             blk_en;
    logic             locked;
    logic [RB_AW-1:0] lock_addr;

    logic do_wr, do_rd, do_init;

    assign do_wr   = host_wr && (host_sel == SEL_DATA);
    assign do_rd   = host_rd && (host_sel == SEL_DATA);
    assign do_init = host_wr && (host_sel == SEL_CTRL) && host_wdata[CTRL_INIT_BIT];
    assign launch_vld = !busy && (do_wr || do_rd || do_init);

    always_comb begin
        if (do_wr)       launch_x.op = OP_WRITE;
        else if (do_rd)  launch_x.op = OP_READ;
        else             launch_x.op = OP_INIT;
        if (!do_wr && !do_rd)       launch_x.addr = '0;
        else if (blk_en && locked)  launch_x.addr = lock_addr;
        else                        launch_x.addr = addr_q;
        launch_x.wdata = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            blk_en    <= 1'b0;
            locked    <= 1'b0;
            lock_addr <= '0;
        end else begin
            if (host_wr && host_sel == SEL_ADDR)
                addr_q <= host_wdata[RB_AW-1:0];
            if (host_wr && host_sel == SEL_CTRL)
                blk_en <= host_wdata[CTRL_BLOCK_BIT];
            if (!blk_en) begin
                locked <= 1'b0;
            end else if (launch_vld && (do_wr || do_rd) && !locked) begin
                locked    <= 1'b1;
                lock_addr <= addr_q;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_ADDR: host_rdata[RB_AW-1:0] = addr_q;
            SEL_DATA: host_rdata = rd_word;
            SEL_CTRL: host_rdata[CTRL_BLOCK_BIT] = blk_en;
            default:  host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rba_timer.sv
module rba_timer #(
    parameter int unsigned TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);

    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    assign hit = run && (cnt == CW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!hit)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rba_xfer_fsm.sv
module rba_xfer_fsm
    import rba_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_vld,
    input  xfer_s            launch_x,
    input  logic             tmo_hit,
    input  logic             rb_ack,
    input  logic [RB_DW-1:0] rb_rdata,
    output logic             busy,
    output logic             rb_req,
    output logic             rb_we,
    output logic             rb_init,
    output logic [RB_AW-1:0] rb_addr,
    output logic [RB_DW-1:0] rb_wdata,
    output logic [RB_DW-1:0] rd_word,
    output logic             err_rd,
    output logic             err_wr,
    output logic             err_init
);

    xfer_st_e st;
    xfer_s    cur;

    assign busy     = (st == ST_ACTIVE);
    assign rb_req   = busy;
    assign rb_we    = busy && (cur.op == OP_WRITE);
    assign rb_init  = busy && (cur.op == OP_INIT);
    assign rb_addr  = cur.addr;
    assign rb_wdata = cur.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= '0;
            rd_word  <= '0;
            err_rd   <= 1'b0;
            err_wr   <= 1'b0;
            err_init <= 1'b0;
        end else begin
            err_rd   <= 1'b0;
            err_wr   <= 1'b0;
            err_init <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (launch_vld) begin
                        cur <= launch_x;
                        st  <= ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (rb_ack) begin
                        st <= ST_IDLE;
                        if (cur.op == OP_READ) rd_word <= rb_rdata;
                    end else if (tmo_hit) begin
                        st <= ST_IDLE;
                        case (cur.op)
                            OP_READ: begin
                                err_rd  <= 1'b1;
                                rd_word <= '0;
                            end
                            OP_WRITE: err_wr   <= 1'b1;
                            default:  err_init <= 1'b1;
                        endcase
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rba_seq.sv
module rba_seq
    import rba_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned TMO_NS = 10_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_wait,
    output logic        rb_req,
    output logic        rb_we,
    output logic        rb_init,
    output logic [11:0] rb_addr,
    output logic [15:0] rb_wdata,
    input  logic        rb_ack,
    input  logic [15:0] rb_rdata,
    output logic        err_rd,
    output logic        err_wr,
    output logic        err_init
);

    localparam int unsigned TMO_CYC = tmo_cycles(CLK_HZ, TMO_NS);

    logic        busy;
    logic        launch_vld;
    xfer_s       launch_x;
    logic        tmo_hit;
    logic [15:0] rd_word;

    assign host_wait = busy;

    rba_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .busy       (busy),
        .rd_word    (rd_word),
        .host_rdata (host_rdata),
        .launch_vld (launch_vld),
        .launch_x   (launch_x)
    );

    rba_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (rb_req),
        .hit (tmo_hit)
    );

    rba_xfer_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .launch_vld (launch_vld),
        .launch_x   (launch_x),
        .tmo_hit    (tmo_hit),
        .rb_ack     (rb_ack),
        .rb_rdata   (rb_rdata),
        .busy       (busy),
        .rb_req     (rb_req),
        .rb_we      (rb_we),
        .rb_init    (rb_init),
        .rb_addr    (rb_addr),
        .rb_wdata   (rb_wdata),
        .rd_word    (rd_word),
        .err_rd     (err_rd),
        .err_wr     (err_wr),
        .err_init   (err_init)
    );

endmodule

// File: rtl/rba_checker.sv
module rba_checker #(
    parameter int unsigned TMO_CYC = 1000
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  host_sel,
    input logic [15:0] host_rdata,
    input logic        host_wait,
    input logic        rb_req,
    input logic        rb_we,
    input logic        rb_init,
    input logic [11:0] rb_addr,
    input logic [15:0] rb_wdata,
    input logic        rb_ack,
    input logic        err_rd,
    input logic        err_wr,
    input logic        err_init
);

    int unsigned req_run;

    always_ff @(posedge clk) begin
        if (rst)         req_run <= 0;
        else if (rb_req) req_run <= req_run + 1;
        else             req_run <= 0;
    end

    assert_addr_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (host_sel == 2'd0) |-> (host_rdata[15:12] == 4'h0));

    assert_req_window_R4: assert property (@(posedge clk) disable iff (rst)
        req_run <= TMO_CYC);

    assert_err_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        err_rd |=> !err_rd);

    assert_err_wr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        err_wr |=> !err_wr);

    assert_init_not_write_R6: assert property (@(posedge clk) disable iff (rst)
        rb_init |-> !rb_we);

    assert_wait_covers_req_R8: assert property (@(posedge clk) disable iff (rst)
        rb_req |-> host_wait);

    assert_req_fall_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rb_req) |-> ($past(rb_ack) || err_rd || err_wr || err_init));

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (rb_req && !rb_ack) |=> (!rb_req || ($stable(rb_addr) && $stable(rb_wdata))));

    assert_err_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_rd, err_wr, err_init}));

endmodule

bind rba_seq rba_checker #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_sel   (host_sel),
    .host_rdata (host_rdata),
    .host_wait  (host_wait),
    .rb_req     (rb_req),
    .rb_we      (rb_we),
    .rb_init    (rb_init),
    .rb_addr    (rb_addr),
    .rb_wdata   (rb_wdata),
    .rb_ack     (rb_ack),
    .err_rd     (err_rd),
    .err_wr     (err_wr),
    .err_init   (err_init)
);

// File: tb/rba_seq_bench.sv
module rba_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ_B = 100_000_000;
    localparam int TMO = CLK_HZ_B / 100_000;   // 10 us window in cycles
    localparam logic [1:0] S_ADDR = 2'd0;
    localparam logic [1:0] S_DATA = 2'd1;
    localparam logic [1:0] S_CTRL = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_wait;
    logic        rb_req, rb_we, rb_init;
    logic [11:0] rb_addr;
    logic [15:0] rb_wdata;
    logic        rb_ack = 1'b0;
    logic [15:0] rb_rdata = 16'h0;
    logic        err_rd, err_wr, err_init;

    int n_checks = 0;
    int n_fail = 0;

    // remote responder configuration
    bit          resp_en = 1'b1;
    int          resp_delay = 0;
    logic [15:0] resp_data = 16'h0;

    // transfer log
    logic [11:0] log_addr [32];
    logic        log_we   [32];
    logic        log_init [32];
    logic [15:0] log_wdata[32];
    int          log_n = 0;
    bit          req_seen = 1'b0;
    int          dly = 0;
    int          cur_len = 0;
    int          last_len = 0;
    int          n_err_rd = 0, n_err_wr = 0, n_err_init = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rba_seq #(.CLK_HZ(CLK_HZ_B)) u_rba_seq (
        .clk(clk), .rst(rst),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wait(host_wait),
        .rb_req(rb_req), .rb_we(rb_we), .rb_init(rb_init),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata),
        .rb_ack(rb_ack), .rb_rdata(rb_rdata),
        .err_rd(err_rd), .err_wr(err_wr), .err_init(err_init)
    );

    // remote model and observers, all on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rb_ack = 1'b0; dly = 0; cur_len = 0; req_seen = 1'b0;
        end else begin
            if (err_rd)   n_err_rd++;
            if (err_wr)   n_err_wr++;
            if (err_init) n_err_init++;
            if (rb_req && !req_seen) begin
                log_addr[log_n % 32]  = rb_addr;
                log_we[log_n % 32]    = rb_we;
                log_init[log_n % 32]  = rb_init;
                log_wdata[log_n % 32] = rb_wdata;
                log_n++;
            end
            req_seen = rb_req;
            if (rb_req) cur_len++;
            else if (cur_len != 0) begin
                last_len = cur_len;
                cur_len = 0;
            end
            if (rb_ack) begin
                rb_ack = 1'b0;
            end else if (rb_req && resp_en) begin
                if (dly == resp_delay) begin
                    rb_ack = 1'b1;
                    rb_rdata = resp_data;
                    dly = 0;
                end else dly++;
            end else if (!rb_req) dly = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (host_wait && g < 5000) begin
            @(negedge clk);
            g++;
        end
        #1;
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        host_sel = s;
        #1 v = host_rdata;
    endtask

    task automatic data_read(output logic [15:0] v);
        @(negedge clk);
        host_sel = S_DATA; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        wait_idle();
        v = host_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R11 req after reset", rb_req, 0);
        check("R11 wait after reset", host_wait, 0);
        check("R11 errors after reset", {err_rd, err_wr, err_init}, 0);
        peek(S_ADDR, v);
        check("R11 address after reset", v, 16'h0000);
    endtask

    task automatic t_addr_reg();
        logic [15:0] v;
        reg_write(S_ADDR, 16'hF5A3);
        peek(S_ADDR, v);
        check("R1 upper bits dropped", v, 16'h05A3);
        reg_write(S_ADDR, 16'hFFFF);
        peek(S_ADDR, v);
        check("R1 full 12-bit address", v, 16'h0FFF);
    endtask

    task automatic t_write();
        int n0 = log_n;
        resp_en = 1'b1; resp_delay = 3;
        reg_write(S_ADDR, 16'h0123);
        reg_write(S_DATA, 16'hBEEF);
        check("R8 wait high during write", host_wait, 1);
        wait_idle();
        check("R2 one transfer", log_n - n0, 1);
        check("R2 address", log_addr[n0 % 32], 12'h123);
        check("R2 write enable", log_we[n0 % 32], 1);
        check("R2 init low", log_init[n0 % 32], 0);
        check("R2 write word", log_wdata[n0 % 32], 16'hBEEF);
        check("R9 req held until ack", last_len, 4);
    endtask

    task automatic t_read();
        logic [15:0] v;
        int n0 = log_n;
        resp_en = 1'b1; resp_delay = 5; resp_data = 16'h5A5A;
        reg_write(S_ADDR, 16'h0456);
        data_read(v);
        check("R3 read word", v, 16'h5A5A);
        check("R3 write enable low", log_we[n0 % 32], 0);
        check("R3 address", log_addr[n0 % 32], 12'h456);
    endtask

    task automatic t_longword();
        int n0 = log_n;
        resp_en = 1'b1; resp_delay = 1;
        reg_write(S_ADDR, 16'h0200);
        reg_write(S_DATA, 16'h1111);
        wait_idle();
        reg_write(S_ADDR, 16'h0201);
        reg_write(S_DATA, 16'h2222);
        wait_idle();
        check("R10 two transfers", log_n - n0, 2);
        check("R10 high half at even", {log_addr[n0 % 32], log_wdata[n0 % 32]}, {12'h200, 16'h1111});
        check("R10 low half at odd", {log_addr[(n0+1) % 32], log_wdata[(n0+1) % 32]}, {12'h201, 16'h2222});
    endtask

    task automatic t_read_timeout();
        logic [15:0] v;
        int e_rd = n_err_rd, e_wr = n_err_wr, e_in = n_err_init;
        resp_en = 1'b1; resp_delay = 0; resp_data = 16'hCAFE;
        data_read(v);
        resp_en = 1'b0;
        data_read(v);
        check("R4 read data zero on timeout", v, 16'h0000);
        check("R4 request window", last_len, TMO);
        check("R4 one read error pulse", n_err_rd - e_rd, 1);
        check("R4 no other errors", (n_err_wr - e_wr) + (n_err_init - e_in), 0);
    endtask

    task automatic t_write_timeout();
        int e_rd = n_err_rd, e_wr = n_err_wr;
        resp_en = 1'b0;
        reg_write(S_DATA, 16'h7777);
        wait_idle();
        check("R5 one write error pulse", n_err_wr - e_wr, 1);
        check("R5 no read error", n_err_rd - e_rd, 0);
        check("R5 request window", last_len, TMO);
    endtask

    task automatic t_init();
        logic [15:0] v;
        int n0 = log_n;
        int e_in = n_err_init;
        resp_en = 1'b1; resp_delay = 2;
        reg_write(S_CTRL, 16'h0001);
        check("R6 wait high during init", host_wait, 1);
        wait_idle();
        check("R6 init request", {log_init[n0 % 32], log_we[n0 % 32]}, 2'b10);
        check("R6 no error on ack", n_err_init - e_in, 0);
        peek(S_CTRL, v);
        check("R6 init bit reads zero", v, 16'h0000);
        resp_en = 1'b0;
        reg_write(S_CTRL, 16'h0001);
        wait_idle();
        check("R6 init error pulse", n_err_init - e_in, 1);
    endtask

    task automatic t_block();
        logic [15:0] v;
        int n0;
        resp_en = 1'b1; resp_delay = 1; resp_data = 16'h0042;
        reg_write(S_CTRL, 16'h0002);
        peek(S_CTRL, v);
        check("R7 block bit reads back", v, 16'h0002);
        n0 = log_n;
        reg_write(S_ADDR, 16'h0010);
        reg_write(S_DATA, 16'h0001);
        wait_idle();
        reg_write(S_ADDR, 16'h0020);
        reg_write(S_DATA, 16'h0002);
        wait_idle();
        data_read(v);
        check("R7 first transfer address", log_addr[n0 % 32], 12'h010);
        check("R7 reused on write", log_addr[(n0+1) % 32], 12'h010);
        check("R7 reused on read", log_addr[(n0+2) % 32], 12'h010);
        reg_write(S_CTRL, 16'h0000);
        reg_write(S_DATA, 16'h0003);
        wait_idle();
        check("R7 released after clear", log_addr[(n0+3) % 32], 12'h020);
    endtask

    task automatic t_busy_drop();
        int n0 = log_n;
        resp_en = 1'b1; resp_delay = 20;
        reg_write(S_ADDR, 16'h0333);
        reg_write(S_DATA, 16'hAAAA);
        reg_write(S_DATA, 16'hBBBB);
        check("R8 wait still high", host_wait, 1);
        reg_write(S_CTRL, 16'h0001);
        wait_idle();
        repeat (3) @(negedge clk);
        #1;
        check("R8 extra accesses dropped", log_n - n0, 1);
        check("R8 first word kept", log_wdata[n0 % 32], 16'hAAAA);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset();
        t_addr_reg();
        t_write();
        t_read();
        t_longword();
        t_read_timeout();
        t_write_timeout();
        t_init();
        t_block();
        t_busy_drop();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule